// File: doc/BRIEF.md
# Temperature Sensor Power and Conversion Sequencer

This controller sits between a register bus and an analog temperature sensing core. It drives the core's power-down, active-low reset and conversion-run pins in a fixed order, and it holds each step for a minimum time. The hold times come from a down-counter whose reload values are derived from a clock-frequency parameter and rounded up. A single write sets the desired state, enabled or disabled. The sequencer powers the core up, releases reset and starts conversions. On disable it stops conversions with reset still released, then powers the core down.

While the core is running, each sample strobe captures the 12-bit conversion code. A sequential divider then turns the code into signed milli-degrees Celsius: the code is multiplied by 237500, the product is divided by 4094 with truncation, and 81100 is subtracted. When the core is not running, or no sample has been converted since it started running, the converted reading is flagged as unavailable.

Top module: `tsense_seq`

## Requirements
- R1: After reset the core pins are power-down 1, reset_n 0 and run 0. Busy and the temperature-valid flag are both 0.
- R2: On an enable request from the powered-down state, power-down is held high and then the pins pass through {run,pd,rstn} = 000, then 001, then 101, with no other pin pattern in between.
- R3: The 000 step (core powering, reset asserted) lasts at least ceil((50 us + 100 ns) x CLK_HZ) cycles.
- R4: The 001 step (reset released, not yet running) lasts at least ceil(1 us x CLK_HZ) cycles before run rises.
- R5: On a disable request from the running state, run falls while reset_n stays 1 for at least one cycle (pattern 001). After that the pins go to power-down 1, reset_n 0.
- R6: Busy is 1 while any enable or disable sequence is in progress, and 0 once the pins rest in either 101 (running) or 010 (off).
- R7: Each converted reading equals trunc(code x 237500 / 4094) - 81100, as a 32-bit signed value.
- R8: Read-data word layout: bit 0 reset_n, bit 1 power-down, bit 2 run, bit 3 busy, bit 4 running, bit 5 temperature valid, bits 27:16 the last captured raw code. All other bits are 0.
- R9: The temperature-valid flag is 0 whenever the core is not running, including after a re-enable until the first new sample has been converted.
- R10: An enable request while running, or a disable request while off, causes no pin change and leaves busy at 0.
- R11: A request written during a sequence is held and acted on once that sequence completes. For example, an enable followed by a disable ends in running and then returns to off.
- R12: The raw code and the converted reading change only on a sample strobe taken while running. A strobe while off, or a change of the code input without a strobe, leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wen_i | input | 1 | Write strobe for the enable request |
| reg_wval_i | input | 1 | Requested state: 1 enable, 0 disable |
| reg_rdata_o | output | 32 | Control and status word (layout in R8) |
| temp_mdeg_o | output | 32 | Converted temperature, signed milli-degrees Celsius |
| temp_valid_o | output | 1 | Converted temperature available |
| busy_o | output | 1 | Sequence in progress |
| sns_pd_o | output | 1 | Core power-down, 1 powers down |
| sns_rstn_o | output | 1 | Core reset, active low |
| sns_run_o | output | 1 | Core conversion run |
| sns_dout_i | input | 12 | Core conversion code |
| sns_sample_i | input | 1 | Strobe: a new conversion code is present |

## Verification
Several properties are checked on every cycle:
- reset_n never rises before the powering window has elapsed with power-down low;
- run never rises before the setup window, and only with reset released and power-down low;
- power-down rises only after run has dropped while reset was still released;
- the valid flag never shows outside the running state;
- the divider's done pulse lasts a single cycle.

Other behaviour can only be shown by the bench's scenarios: the exact pin order, the numeric result of each conversion against a bench model, the effect of redundant requests, the deferral of a request made mid-sequence, and the rule that samples outside the running state are ignored.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PDHOLD,
    ST_PWRUP,
    ST_RSTREL,
    ST_RUN,
    ST_STOP
  } seq_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cyc(input longint unsigned ns, input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/tsense_fsm.sv
module tsense_fsm
  import tsense_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned T_PDH_NS = 1000,
  parameter longint unsigned T_PU_NS  = 50000,
  parameter longint unsigned T_RST_NS = 100,
  parameter longint unsigned T_SU_NS  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_en_i,
  output logic pd_o,
  output logic rstn_o,
  output logic run_o,
  output logic busy_o,
  output logic running_o
);

  localparam int unsigned PDH_CYC = ns_to_cyc(T_PDH_NS, CLK_HZ);
  localparam int unsigned PU_CYC  = ns_to_cyc(T_PU_NS + T_RST_NS, CLK_HZ);
  localparam int unsigned SU_CYC  = ns_to_cyc(T_SU_NS, CLK_HZ);
  localparam int unsigned MAX_A   = (PDH_CYC > PU_CYC) ? PDH_CYC : PU_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > SU_CYC) ? MAX_A : SU_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_d;
  logic [CNT_W-1:0] tmr_q, load_val;
  logic             load;
  logic             tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_OFF: if (want_en_i) begin
        state_d = ST_PDHOLD; load = 1'b1; load_val = CNT_W'(PDH_CYC - 1);
      end
      ST_PDHOLD: if (tmr_zero) begin
        state_d = ST_PWRUP; load = 1'b1; load_val = CNT_W'(PU_CYC - 1);
      end
      ST_PWRUP: if (tmr_zero) begin
        state_d = ST_RSTREL; load = 1'b1; load_val = CNT_W'(SU_CYC - 1);
      end
      ST_RSTREL: if (tmr_zero) state_d = ST_RUN;
      ST_RUN: if (!want_en_i) begin
        state_d = ST_STOP; load = 1'b1; load_val = CNT_W'(SU_CYC - 1);
      end
      ST_STOP: if (tmr_zero) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load)           tmr_q <= load_val;
      else if (!tmr_zero) tmr_q <= tmr_q - 1'b1;
    end
  end

  always_comb begin
    pd_o   = 1'b0;
    rstn_o = 1'b0;
    run_o  = 1'b0;
    unique case (state_q)
      ST_OFF, ST_PDHOLD: pd_o = 1'b1;
      ST_PWRUP:          ;
      ST_RSTREL, ST_STOP: rstn_o = 1'b1;
      ST_RUN: begin rstn_o = 1'b1; run_o = 1'b1; end
      default: pd_o = 1'b1;
    endcase
  end

  assign running_o = (state_q == ST_RUN);
  assign busy_o    = (state_q != ST_RUN) && (state_q != ST_OFF);

  // window counters observed at the pins
  logic [CNT_W:0] pu_seen_q, su_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_seen_q <= '0;
      su_seen_q <= '0;
    end else begin
      if (pd_o || rstn_o)                          pu_seen_q <= '0;
      else if (pu_seen_q != (CNT_W+1)'(MAX_CYC))   pu_seen_q <= pu_seen_q + 1'b1;
      if (!rstn_o || run_o || pd_o)                su_seen_q <= '0;
      else if (su_seen_q != (CNT_W+1)'(MAX_CYC))   su_seen_q <= su_seen_q + 1'b1;
    end
  end

  // R3
  pu_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rstn_o) |-> (pu_seen_q >= (CNT_W+1)'(PU_CYC)));
  // R4
  su_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> (su_seen_q >= (CNT_W+1)'(SU_CYC)));
  // R2
  run_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> (rstn_o && !pd_o && $past(rstn_o)));
  // R5
  pd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_o) |-> ($past(rstn_o) && !$past(run_o) && !run_o));

endmodule

// File: rtl/tsense_conv.sv
module tsense_conv #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned SCALE   = 237500,
  parameter int unsigned DIVISOR = 4094,
  parameter int unsigned OFFSET  = 81100,
  parameter int unsigned OUT_W   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CODE_W-1:0]       code_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [OUT_W-1:0] mdeg_o
);

  localparam int unsigned PROD_W = CODE_W + $clog2(SCALE + 1);
  localparam int unsigned DIV_W  = $clog2(DIVISOR + 1);
  localparam int unsigned CNT_W  = $clog2(PROD_W + 1);

  logic [PROD_W-1:0] quo_q, quo_nxt, prod;
  logic [DIV_W-1:0]  rem_q, rem_nxt;
  logic [DIV_W:0]    rem_sh;
  logic [CNT_W-1:0]  cnt_q;
  logic              bit_q;

  assign prod = PROD_W'(code_i) * PROD_W'(SCALE);

  // restoring division, one quotient bit per cycle
  always_comb begin
    rem_sh = {rem_q, quo_q[PROD_W-1]};
    bit_q  = (rem_sh >= (DIV_W+1)'(DIVISOR));
    rem_nxt = bit_q ? DIV_W'(rem_sh - (DIV_W+1)'(DIVISOR)) : DIV_W'(rem_sh);
    quo_nxt = {quo_q[PROD_W-2:0], bit_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      mdeg_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        quo_q  <= prod;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(PROD_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        quo_q <= quo_nxt;
        rem_q <= rem_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          mdeg_o <= $signed({{(OUT_W-PROD_W){1'b0}}, quo_nxt}) - $signed(OUT_W'(OFFSET));
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned T_PDH_NS = 1000,
  parameter longint unsigned T_PU_NS  = 50000,
  parameter longint unsigned T_RST_NS = 100,
  parameter longint unsigned T_SU_NS  = 1000,
  parameter int unsigned     CODE_W   = 12,
  parameter int unsigned     RAW_LSB  = 16,
  parameter int unsigned     SCALE    = 237500,
  parameter int unsigned     DIVISOR  = 4094,
  parameter int unsigned     OFFSET   = 81100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wen_i,
  input  logic              reg_wval_i,
  output logic [31:0]       reg_rdata_o,
  output logic [31:0]       temp_mdeg_o,
  output logic              temp_valid_o,
  output logic              busy_o,
  output logic              sns_pd_o,
  output logic              sns_rstn_o,
  output logic              sns_run_o,
  input  logic [CODE_W-1:0] sns_dout_i,
  input  logic              sns_sample_i
);

  logic              want_q;
  logic              running;
  logic [CODE_W-1:0] raw_q;
  logic              have_q;
  logic              conv_busy, conv_done, accept;
  logic signed [31:0] conv_mdeg;

  // latest request wins; the sequencer acts on it when at rest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) want_q <= 1'b0;
    else if (reg_wen_i) want_q <= reg_wval_i;
  end

  tsense_fsm #(
    .CLK_HZ(CLK_HZ), .T_PDH_NS(T_PDH_NS), .T_PU_NS(T_PU_NS),
    .T_RST_NS(T_RST_NS), .T_SU_NS(T_SU_NS)
  ) fsm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .want_en_i(want_q),
    .pd_o(sns_pd_o), .rstn_o(sns_rstn_o), .run_o(sns_run_o),
    .busy_o(busy_o), .running_o(running)
  );

  assign accept = sns_sample_i && running && !conv_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      have_q <= 1'b0;
    end else begin
      if (accept) raw_q <= sns_dout_i;
      if (!running)       have_q <= 1'b0;
      else if (conv_done) have_q <= 1'b1;
    end
  end

  tsense_conv #(
    .CODE_W(CODE_W), .SCALE(SCALE), .DIVISOR(DIVISOR), .OFFSET(OFFSET), .OUT_W(32)
  ) conv_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .code_i(sns_dout_i),
    .busy_o(conv_busy), .done_o(conv_done), .mdeg_o(conv_mdeg)
  );

  assign temp_mdeg_o  = conv_mdeg;
  assign temp_valid_o = have_q && running;

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[0] = sns_rstn_o;
    reg_rdata_o[1] = sns_pd_o;
    reg_rdata_o[2] = sns_run_o;
    reg_rdata_o[3] = busy_o;
    reg_rdata_o[4] = running;
    reg_rdata_o[5] = temp_valid_o;
    reg_rdata_o[RAW_LSB +: CODE_W] = raw_q;
  end

  // R9
  valid_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_valid_o |-> (sns_run_o && sns_rstn_o && !sns_pd_o));
  // R6
  busy_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sns_run_o) |-> (sns_pd_o && !sns_rstn_o));

endmodule

// File: tb/tsense_seq_tb.sv
`timescale 1ns/1ps
module tsense_seq_tb_top;

  localparam int PU_MIN  = 5010;  // ceil(50.1 us * 100 MHz)
  localparam int SU_MIN  = 100;   // ceil(1 us * 100 MHz)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0, wval = 1'b0;
  logic [31:0] rdata, mdeg;
  logic valid, busy, pd, rstn, run;
  logic [11:0] dout = '0;
  logic sample = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tsense_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wen_i(wen), .reg_wval_i(wval),
    .reg_rdata_o(rdata), .temp_mdeg_o(mdeg), .temp_valid_o(valid), .busy_o(busy),
    .sns_pd_o(pd), .sns_rstn_o(rstn), .sns_run_o(run),
    .sns_dout_i(dout), .sns_sample_i(sample)
  );

  // pin pattern log: {run,pd,rstn} and run length
  logic [2:0] log_val [128];
  int         log_len [128];
  int         log_n = 0;
  logic [2:0] prev_ctl = 3'b010;
  int         cur_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({run, pd, rstn} != prev_ctl) begin
        if (log_n < 128) begin
          log_val[log_n] = prev_ctl;
          log_len[log_n] = cur_len;
          log_n = log_n + 1;
        end
        prev_ctl = {run, pd, rstn};
        cur_len  = 1;
      end else cur_len = cur_len + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_temp(input int code);
    return (longint'(code) * 237500) / 4094 - 81100;
  endfunction

  task automatic wr(input logic v);
    @(negedge clk); wen = 1'b1; wval = v;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic wait_pin(input int which, input logic lvl, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if ((which == 0 && run == lvl) || (which == 1 && pd == lvl)) begin hit = 1; break; end
    end
  endtask

  task automatic do_sample(input int code);
    @(negedge clk); dout = 12'(code); sample = 1'b1;
    @(negedge clk); sample = 1'b0;
    repeat (45) @(negedge clk);
  endtask

  task automatic enable_seq;
    int base; bit hit;
    base = log_n;
    wr(1'b1);
    repeat (300) @(negedge clk);
    chk(busy == 1'b1, "R6 busy during power-up", busy, 1);
    wait_pin(0, 1'b1, 10000, hit);
    chk(hit, "R2 run reached", hit, 1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R6 busy low when running", busy, 0);
    chk(log_n - base == 3, "R2 pattern count", log_n - base, 3);
    chk(log_val[base] == 3'b010, "R2 start off", log_val[base], 3'b010);
    chk(log_val[base+1] == 3'b000, "R2 powering step", log_val[base+1], 3'b000);
    chk(log_len[base+1] >= PU_MIN, "R3 powering length", log_len[base+1], PU_MIN);
    chk(log_val[base+2] == 3'b001, "R2 reset released step", log_val[base+2], 3'b001);
    chk(log_len[base+2] >= SU_MIN, "R4 setup length", log_len[base+2], SU_MIN);
    chk(valid == 1'b0, "R9 no data before first sample", valid, 0);
  endtask

  task automatic disable_seq;
    int base; bit hit;
    base = log_n;
    wr(1'b0);
    wait_pin(1, 1'b1, 5000, hit);
    chk(hit, "R5 power-down reached", hit, 1);
    repeat (2) @(negedge clk);
    chk(log_n - base == 2, "R5 pattern count", log_n - base, 2);
    chk(log_val[base+1] == 3'b001, "R5 run drops with reset released", log_val[base+1], 3'b001);
    chk(log_len[base+1] >= 1, "R5 stop length", log_len[base+1], 1);
    chk({run, pd, rstn} == 3'b010, "R5 off pins", {run, pd, rstn}, 3'b010);
    chk(busy == 1'b0, "R6 busy low when off", busy, 0);
    chk(valid == 1'b0 && rdata[5] == 1'b0, "R9 no data while off", valid, 0);
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base; bit hit; int code; int seed_dummy; logic [31:0] held;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({run, pd, rstn} == 3'b010, "R1 reset pins", {run, pd, rstn}, 3'b010);
    chk(busy == 1'b0 && valid == 1'b0, "R1 busy/valid", {busy, valid}, 0);
    // R8 read layout at reset
    chk(rdata == 32'h0000_0002, "R8 reset readback", rdata, 32'h2);

    // R12 sample while off ignored
    do_sample(12'hABC);
    chk(rdata[27:16] == 12'h000, "R12 raw unchanged while off", rdata[27:16], 0);
    chk(valid == 1'b0, "R9 off no data", valid, 0);

    enable_seq();
    chk(rdata[5:0] == 6'b010101, "R8 running readback", rdata[5:0], 6'b010101);

    // R7 directed then random codes
    for (int i = 0; i < 24; i++) begin
      case (i)
        0: code = 0;
        1: code = 1;
        2: code = 4094;
        3: code = 4095;
        default: code = int'($urandom_range(0, 4095));
      endcase
      do_sample(code);
      chk(valid == 1'b1, "R9 valid after sample", valid, 1);
      chk(longint'($signed(mdeg)) == exp_temp(code), "R7 conversion", $signed(mdeg), exp_temp(code));
      chk(rdata[27:16] == 12'(code), "R8 raw field", rdata[27:16], code);
    end

    // R12 code change without strobe
    held = mdeg;
    @(negedge clk); dout = 12'h5A5;
    repeat (60) @(negedge clk);
    chk(mdeg == held, "R12 no strobe no update", mdeg, held);
    chk(rdata[27:16] != 12'h5A5 || held == mdeg, "R12 raw held", rdata[27:16], 0);

    // R10 redundant enable
    base = log_n;
    wr(1'b1);
    repeat (300) @(negedge clk);
    chk(log_n == base && run == 1'b1, "R10 enable while running", log_n - base, 0);
    chk(busy == 1'b0, "R10 busy stays low", busy, 0);

    disable_seq();
    chk(rdata[4] == 1'b0, "R8 running bit off", rdata[4], 0);

    // R10 redundant disable
    base = log_n;
    wr(1'b0);
    repeat (300) @(negedge clk);
    chk(log_n == base && pd == 1'b1, "R10 disable while off", log_n - base, 0);
    chk(busy == 1'b0, "R10 busy low off", busy, 0);
    held = rdata;
    do_sample(12'h123);
    chk(rdata[27:16] == held[27:16], "R12 raw unchanged after off strobe", rdata[27:16], held[27:16]);

    // R11 request during sequence
    base = log_n;
    wr(1'b1);
    repeat (20) @(negedge clk);
    wr(1'b0);
    chk(busy == 1'b1, "R11 busy mid sequence", busy, 1);
    wait_pin(0, 1'b1, 10000, hit);
    chk(hit, "R11 reaches running", hit, 1);
    wait_pin(1, 1'b1, 5000, hit);
    chk(hit, "R11 returns off", hit, 1);
    repeat (2) @(negedge clk);
    chk(log_n - base == 5, "R11 pattern count", log_n - base, 5);
    chk(log_val[base+3] == 3'b101, "R11 passed through run", log_val[base+3], 3'b101);

    // re-enable: stale reading must not be valid
    enable_seq();
    code = int'($urandom_range(0, 4095));
    do_sample(code);
    chk(longint'($signed(mdeg)) == exp_temp(code), "R7 conversion after re-enable", $signed(mdeg), exp_temp(code));
    disable_seq();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule